// File: doc/BRIEF.md
# PAM3 Burst Symbol Encoder

This block turns one burst payload into a stream of ternary line symbols for an 11-lane link. A payload has 256 data bits, 18 CRC bits and a 2-bit severity/poison status field. The block cuts these into code groups of three sizes. Each 11-bit data group becomes 7 ternary symbols. The 3 data bits left over, and each 3-bit CRC group, become 2 symbols. The status field becomes 1 symbol. That gives 176 symbols, which exactly fill 16 beats of 11 lanes.

The producer hands a burst over on a valid/ready interface. The handover completes on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no burst is being sent. A producer that holds `in_valid` high during a burst just waits, and its payload is taken in the first cycle after the burst ends. The payload may change freely until it is accepted.

All groups are encoded at acceptance. The block then sends one 11-lane word per cycle for 16 cycles, and `sym_valid` marks these cycles. The output side has no back-pressure: a started burst always runs to the end.

Top module: `pam3_burst_enc`

## Requirements
- R1: Data group g (0 to 22) is `in_data[11g+10:11g]`, read as an unsigned number. It is written as 7 base-3 digits, least significant digit first, at stream positions 7g to 7g+6.
- R2: The top three data bits `in_data[255:253]`, read as a number from 0 to 7, become two base-3 digits, low digit first, at stream positions 161 and 162.
- R3: CRC group k (0 to 5) is `in_crc[3k+2:3k]`. It becomes two base-3 digits, low digit first, at stream positions 163+2k and 164+2k.
- R4: The status symbol at stream position 175 is -1 for status 00, 0 for status 01, and +1 for status 10 and 11.
- R5: A digit 0, 1 or 2 is sent as the 2-bit code 00 (-1), 01 (0) or 10 (+1). The code 11 never appears on `sym_word` while `sym_valid` is high.
- R6: Stream position n is sent in beat n/11 on lane n%11. Lane l occupies `sym_word[2l+1:2l]`.
- R7: `in_ready` is high exactly when no burst is in progress. A burst is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R8: After each accepted burst, `sym_valid` is high for exactly 16 consecutive cycles, starting in the cycle right after acceptance, and then drops.
- R9: While a burst is being sent, changes to `in_data`, `in_crc`, `in_status` and `in_valid` do not affect the symbols sent. A held `in_valid` is accepted in the first cycle after the burst ends.
- R10: After reset, `in_ready` is 1 and `sym_valid` is 0.
- R11: A 2-symbol group (positions 161 to 174, paired from 161) never sends the digit pair (2,2), that is, +1 followed by +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Block idle, payload can be accepted |
| in_data | input | 256 | Data bits of the burst |
| in_crc | input | 18 | CRC bits of the burst |
| in_status | input | 2 | Severity/poison status bits |
| sym_valid | output | 1 | A symbol word is present this cycle |
| sym_word | output | 22 | 11 lanes of 2-bit symbol codes, lane 0 in the low bits |

## Verification
The assertions check the timing and legality rules on every cycle:
- the 2-bit code 11 never appears;
- each burst lasts exactly 16 beats and starts one cycle after acceptance;
- a 2-symbol group never sends the forbidden +1,+1 pair.

The mapping from digits to values cannot be checked by the assertions. This covers the LSD-first order of the base-3 digits, the boundaries between groups, the status folding and the placement across beats and lanes. Only the bench's scenarios show these: they compare each beat with a reference model for zero, all-ones and random payloads, for every status value, and with a producer that is held off while a burst is being sent.

// File: rtl/pam3_enc_pkg.sv
package pam3_enc_pkg;
  typedef enum logic [1:0] {
    LVL_NEG  = 2'b00,
    LVL_ZERO = 2'b01,
    LVL_POS  = 2'b10
  } pam3_lvl_e;

  localparam logic [1:0] CODE_BAD = 2'b11;

  function automatic logic [1:0] digit_to_code(input int d);
    case (d)
      0:       return LVL_NEG;
      1:       return LVL_ZERO;
      default: return LVL_POS;
    endcase
  endfunction
endpackage

// File: rtl/pam3_group_enc.sv
module pam3_group_enc #(
  parameter int BITS = 11,
  parameter int SYMS = 7,
  parameter bit SAT  = 1'b0
) (
  input  logic [BITS-1:0]   grp,
  output logic [2*SYMS-1:0] syms
);
  import pam3_enc_pkg::*;
  localparam int MAXV = 3**SYMS - 1;

  always_comb begin
    int v;
    v = int'(grp);
    if (SAT && v > MAXV) v = MAXV;
    for (int i = 0; i < SYMS; i++) begin
      syms[2*i +: 2] = digit_to_code(v % 3);
      v = v / 3;
    end
  end
endmodule

// File: rtl/pam3_beat_shifter.sv
module pam3_beat_shifter #(
  parameter int WORD_W = 22,
  parameter int BEATS  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [WORD_W*BEATS-1:0]   load_vec,
  output logic                      busy,
  output logic [WORD_W-1:0]         word
);
  localparam int VEC_W = WORD_W * BEATS;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [VEC_W-1:0] sreg;
  logic [CW-1:0]    beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      busy <= 1'b0;
      beat <= '0;
    end else if (load) begin
      sreg <= load_vec;
      busy <= 1'b1;
      beat <= '0;
    end else if (busy) begin
      sreg <= sreg >> WORD_W;
      beat <= beat + 1'b1;
      if (beat == CW'(BEATS - 1)) busy <= 1'b0;
    end
  end

  assign word = sreg[WORD_W-1:0];
endmodule

// File: rtl/pam3_burst_enc.sv
module pam3_burst_enc #(
  parameter int LANES      = 11,
  parameter int BEATS      = 16,
  parameter int DATA_W     = 256,
  parameter int CRC_W      = 18,
  parameter int BIG_BITS   = 11,
  parameter int BIG_SYMS   = 7,
  parameter int SMALL_BITS = 3,
  parameter int SMALL_SYMS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [CRC_W-1:0]     in_crc,
  input  logic [1:0]           in_status,
  output logic                 sym_valid,
  output logic [2*LANES-1:0]   sym_word
);
  localparam int N_BIG   = DATA_W / BIG_BITS;
  localparam int N_CRC   = CRC_W / SMALL_BITS;
  localparam int OFF_REM = N_BIG * BIG_SYMS;
  localparam int OFF_CRC = OFF_REM + SMALL_SYMS;
  localparam int OFF_ST  = OFF_CRC + N_CRC * SMALL_SYMS;
  localparam int N_SYM   = OFF_ST + 1;
  localparam int WORD_W  = 2 * LANES;
  localparam int VEC_W   = WORD_W * BEATS;

  logic [VEC_W-1:0] sym_vec;
  logic             busy;
  logic             accept;

  for (genvar g = 0; g < N_BIG; g++) begin : g_big
    pam3_group_enc #(.BITS(BIG_BITS), .SYMS(BIG_SYMS), .SAT(1'b0)) u_enc (
      .grp  (in_data[g*BIG_BITS +: BIG_BITS]),
      .syms (sym_vec[2*g*BIG_SYMS +: 2*BIG_SYMS])
    );
  end

  pam3_group_enc #(.BITS(SMALL_BITS), .SYMS(SMALL_SYMS), .SAT(1'b0)) u_rem (
    .grp  (in_data[DATA_W-1 -: SMALL_BITS]),
    .syms (sym_vec[2*OFF_REM +: 2*SMALL_SYMS])
  );

  for (genvar k = 0; k < N_CRC; k++) begin : g_crc
    pam3_group_enc #(.BITS(SMALL_BITS), .SYMS(SMALL_SYMS), .SAT(1'b0)) u_enc (
      .grp  (in_crc[k*SMALL_BITS +: SMALL_BITS]),
      .syms (sym_vec[2*(OFF_CRC + k*SMALL_SYMS) +: 2*SMALL_SYMS])
    );
  end

  pam3_group_enc #(.BITS(2), .SYMS(1), .SAT(1'b1)) u_stat (
    .grp  (in_status),
    .syms (sym_vec[2*OFF_ST +: 2])
  );

  if (VEC_W > 2 * N_SYM) begin : g_pad
    assign sym_vec[VEC_W-1:2*N_SYM] = '0;
  end

  assign accept   = in_valid && in_ready;
  assign in_ready = !busy;

  pam3_beat_shifter #(.WORD_W(WORD_W), .BEATS(BEATS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_vec (sym_vec),
    .busy     (busy),
    .word     (sym_word)
  );

  assign sym_valid = busy;
endmodule

// File: rtl/pam3_burst_enc_chk.sv
module pam3_burst_enc_chk #(
  parameter int LANES     = 11,
  parameter int BEATS     = 16,
  parameter int PAIR_BASE = 161,
  parameter int N_PAIRS   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               sym_valid,
  input logic [2*LANES-1:0] sym_word
);
  localparam int CW = $clog2(BEATS + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    last_q;
  logic          bad_code;
  logic          bad_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      last_q <= 2'b00;
    end else begin
      cnt    <= sym_valid ? cnt + 1'b1 : '0;
      last_q <= sym_word[2*LANES-1 -: 2];
    end
  end

  always_comb begin
    bad_code = 1'b0;
    bad_pair = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      int pos;
      int pidx;
      logic [1:0] cur;
      logic [1:0] prv;
      pos  = int'(cnt) * LANES + l;
      pidx = (l == 0) ? 0 : 2*l - 2;
      cur  = sym_word[2*l +: 2];
      prv  = (l == 0) ? last_q : sym_word[pidx +: 2];
      if (cur == 2'b11) bad_code = 1'b1;
      if (pos > PAIR_BASE && pos < PAIR_BASE + 2*N_PAIRS &&
          ((pos - PAIR_BASE) % 2) == 1 && cur == 2'b10 && prv == 2'b10)
        bad_pair = 1'b1;
    end
  end

  a_r5_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !bad_code);

  a_r11_no_pos_pair: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !bad_pair);

  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (sym_valid && !in_ready));

  a_r8_start_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid) |-> $past(in_valid && in_ready));

  a_r8_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (cnt < CW'(BEATS)));

  a_r8_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sym_valid) |-> (cnt == CW'(BEATS)));
endmodule

bind pam3_burst_enc pam3_burst_enc_chk #(
  .LANES(LANES), .BEATS(BEATS), .PAIR_BASE(OFF_REM), .N_PAIRS(1 + N_CRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sym_valid(sym_valid), .sym_word(sym_word)
);

// File: tb/sim_pam3_burst_enc.sv
module sim_pam3_burst_enc;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 11;
  localparam int BEATS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_data = '0;
  logic [17:0]  in_crc = '0;
  logic [1:0]   in_status = '0;
  logic         sym_valid;
  logic [21:0]  sym_word;

  int n_checks = 0;
  int n_fail = 0;
  logic [21:0] got [BEATS];

  always #(CLK_PERIOD/2) clk = ~clk;

  pam3_burst_enc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_crc(in_crc), .in_status(in_status),
    .sym_valid(sym_valid), .sym_word(sym_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int dig(input int v, input int k);
    int p = 1;
    for (int i = 0; i < k; i++) p = p * 3;
    return (v / p) % 3;
  endfunction

  // Reference: stream position n -> 2-bit code (R1..R5)
  function automatic logic [1:0] ref_sym(input logic [255:0] d, input logic [17:0] c,
                                          input logic [1:0] s, input int n);
    int v, k;
    if (n < 161) begin
      v = int'(d[11*(n/7) +: 11]); k = n % 7;
    end else if (n < 163) begin
      v = int'(d[255:253]); k = n - 161;
    end else if (n < 175) begin
      v = int'(c[3*((n-163)/2) +: 3]); k = (n - 163) % 2;
    end else begin
      return (s == 2'b00) ? 2'b00 : (s == 2'b01) ? 2'b01 : 2'b10;
    end
    return 2'(dig(v, k));
  endfunction

  function automatic logic [21:0] ref_word(input logic [255:0] d, input logic [17:0] c,
                                            input logic [1:0] s, input int b);
    logic [21:0] w;
    for (int l = 0; l < LANES; l++) w[2*l +: 2] = ref_sym(d, c, s, b*LANES + l);
    return w;
  endfunction

  // Called at a falling edge where beat 0 should be present.
  task automatic check_beats(input logic [255:0] d, input logic [17:0] c,
                             input logic [1:0] s, input string name);
    for (int b = 0; b < BEATS; b++) begin
      got[b] = sym_word;
      chk(sym_valid == 1'b1, "R8", {name, " valid during burst"}, 64'(sym_valid), 64'd1);
      chk(in_ready == 1'b0, "R7", {name, " ready low while busy"}, 64'(in_ready), 64'd0);
      chk(sym_word == ref_word(d, c, s, b), "R1/R2/R3/R6",
          $sformatf("%s beat %0d", name, b), 64'(sym_word), 64'(ref_word(d, c, s, b)));
      for (int l = 0; l < LANES; l++)
        chk(sym_word[2*l +: 2] != 2'b11, "R5", {name, " legal code"},
            64'(sym_word[2*l +: 2]), 64'd0);
      @(negedge clk);
    end
    chk(got[15][21:20] == ref_sym(d, c, s, 175), "R4", {name, " status symbol"},
        64'(got[15][21:20]), 64'(ref_sym(d, c, s, 175)));
    for (int p = 161; p < 175; p += 2)
      chk(!(got[p/11][2*(p%11) +: 2] == 2'b10 && got[(p+1)/11][2*((p+1)%11) +: 2] == 2'b10),
          "R11", {name, " no +1,+1 pair"}, 64'(p), 64'd0);
    chk(sym_valid == 1'b0, "R8", {name, " valid drops after 16"}, 64'(sym_valid), 64'd0);
    chk(in_ready == 1'b1, "R7", {name, " ready after burst"}, 64'(in_ready), 64'd1);
  endtask

  task automatic run_burst(input logic [255:0] d, input logic [17:0] c,
                           input logic [1:0] s, input string name);
    @(negedge clk);
    in_data = d; in_crc = c; in_status = s; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R7", {name, " ready before accept"}, 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0; in_data = ~d; in_crc = ~c; in_status = ~s;  // R9 junk
    check_beats(d, c, s, name);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R10", "ready after reset", 64'(in_ready), 64'd1);
    chk(sym_valid == 1'b0, "R10", "valid after reset", 64'(sym_valid), 64'd0);
  endtask

  task automatic t_idle();
    in_valid = 1'b0; in_data = '1;
    repeat (5) begin
      @(negedge clk);
      chk(sym_valid == 1'b0, "R7", "no start without in_valid", 64'(sym_valid), 64'd0);
    end
  endtask

  task automatic t_zero();
    run_burst('0, '0, 2'b00, "zeros");
  endtask

  task automatic t_ones();
    run_burst('1, '1, 2'b11, "ones");
  endtask

  task automatic t_status_sweep();
    for (int s = 0; s < 4; s++) begin
      logic [255:0] d;
      for (int w = 0; w < 8; w++) d[32*w +: 32] = $urandom;
      run_burst(d, 18'($urandom), 2'(s), $sformatf("status%0d", s));
    end
  endtask

  task automatic t_backpressure();
    logic [255:0] da, db;
    logic [17:0]  ca, cb;
    for (int w = 0; w < 8; w++) begin da[32*w +: 32] = $urandom; db[32*w +: 32] = $urandom; end
    ca = 18'($urandom); cb = 18'($urandom);
    @(negedge clk);
    in_data = da; in_crc = ca; in_status = 2'b01; in_valid = 1'b1;
    @(negedge clk);
    in_data = db; in_crc = cb; in_status = 2'b10;  // R9: held valid with new payload
    check_beats(da, ca, 2'b01, "bp_first");
    @(negedge clk);
    in_valid = 1'b0;
    check_beats(db, cb, 2'b10, "bp_second R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_zero();
    t_ones();
    t_status_sweep();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule